// File: doc/BRIEF.md
# Per-ID Ordered Completion Scheduler

This block sits on the slave side of a split-transaction interface. It accepts tagged read and write requests and decides when each one may report completion. Every request carries a transaction ID and a service latency in cycles. Completions with different IDs may overtake one another. Completions that share an ID always leave in the order their requests were accepted.

Reads and writes form two separate ordering domains. A read and a write with the same ID value never wait on each other. Each domain has its own request handshake and its own completion handshake, both valid/ready. Several requests per domain may be outstanding at once.

A strict mode input makes both domains complete in plain arrival order, whatever the IDs. Only the ordering decision and the handshakes are built here. Data storage is left to the surrounding logic.

Top module: `orderedCplSched`

## Requirements
- R1: After a synchronous active-low reset, both request-ready outputs are high and both completion-valid outputs are low.
- R2: A request accepted with latency L (0 to 15) at clock edge T is never offered as a completion before the cycle that follows edge T+L.
- R3: In non-strict mode, a request whose latency has run out is offered even while an older request with a different ID is still pending in the same domain.
- R4: Within one domain, completions that share an ID leave in the order their requests were accepted.
- R5: The read and write domains are independent: an outstanding write never delays a read with the same ID value, and the reverse holds too.
- R6: While the strict mode input is high, a domain offers only its oldest outstanding request, whatever the IDs.
- R7: Each domain holds 4 slots. A new request takes the lowest-numbered free slot. When several requests are ready in the same cycle, the one in the lowest-numbered slot is offered.
- R8: Once a completion is offered, its valid stays high and its ID stays unchanged until ready is sampled high. The slot is released on that same edge.
- R9: A domain can hold up to 4 outstanding requests. Its request-ready is low exactly when all 4 slots are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| strictMode | input | 1 | 1: complete each domain in arrival order |
| rdReqValid | input | 1 | Read request valid |
| rdReqReady | output | 1 | Read request accepted when high with valid |
| rdReqId | input | 2 | Read request ID |
| rdReqLat | input | 4 | Read service latency in cycles |
| rdCplValid | output | 1 | Read completion offered |
| rdCplReady | input | 1 | Read completion taken |
| rdCplId | output | 2 | ID of the offered read completion |
| wrReqValid | input | 1 | Write request valid |
| wrReqReady | output | 1 | Write request accepted when high with valid |
| wrReqId | input | 2 | Write request ID |
| wrReqLat | input | 4 | Write service latency in cycles |
| wrCplValid | output | 1 | Write completion offered |
| wrCplReady | input | 1 | Write completion taken |
| wrCplId | output | 2 | ID of the offered write completion |

## Verification
A corrupted age relation between slots shows at the completion port in the first cycle where it matters. Either a younger same-ID request appears as the offered ID, or valid stays low while the model expects an offer. A wrong latency count moves the rising edge of completion-valid off the expected cycle. A slot that is released wrongly or never released changes request-ready on the next cycle, or changes which slot the next request lands in. That second effect shows up later as a tie broken the wrong way. Because the bench compares every output on every cycle, each of these faults is seen within the cycles of the transaction it affects, not only at the end of the run.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
  // strobes issued by the control half to the slot table
  typedef struct packed {
    logic take;    // load the chosen free slot with the incoming request
    logic retire;  // release the slot whose completion was handed over
  } tblStrobe_t;
endpackage

// File: rtl/schedTable.sv
`timescale 1ns/1ps
module schedTable
  import sched_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ID_W  = 2,
  parameter int LAT_W = 4,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strictMode,
  input  tblStrobe_t       strobe,
  input  logic [IDX_W-1:0] allocIdx,
  input  logic [ID_W-1:0]  allocId,
  input  logic [LAT_W-1:0] allocLat,
  input  logic [IDX_W-1:0] freeIdx,
  input  logic [IDX_W-1:0] selIdx,
  output logic [DEPTH-1:0] validMask,
  output logic [DEPTH-1:0] eligMask,
  output logic [ID_W-1:0]  selId
);

  logic [DEPTH-1:0] entValid;
  logic [ID_W-1:0]  entId     [DEPTH];
  logic [LAT_W-1:0] entCnt    [DEPTH];
  // olderMask[i][j] set: slot j holds a request accepted before slot i's
  logic [DEPTH-1:0] olderMask [DEPTH];
  logic [DEPTH-1:0] freeVec;
  logic [DEPTH-1:0] blockedVec;

  assign freeVec   = strobe.retire ? (DEPTH'(1) << freeIdx) : '0;
  assign validMask = entValid;
  assign selId     = entId[selIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entId[i]     <= '0;
        entCnt[i]    <= '0;
        olderMask[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (entValid[i] && (entCnt[i] != '0))
          entCnt[i] <= entCnt[i] - 1'b1;
        if (strobe.retire)
          olderMask[i][freeIdx] <= 1'b0;
        if (strobe.retire && (freeIdx == IDX_W'(i)))
          entValid[i] <= 1'b0;
        if (strobe.take && (allocIdx == IDX_W'(i))) begin
          entValid[i]  <= 1'b1;
          entId[i]     <= allocId;
          entCnt[i]    <= allocLat;
          olderMask[i] <= entValid & ~freeVec;
        end
      end
    end
  end

  // a slot may complete once its count is spent and no older slot
  // of the same ID (or of any ID in strict mode) is still outstanding
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      blockedVec[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if ((j != i) && olderMask[i][j] && entValid[j] &&
            (strictMode || (entId[j] == entId[i])))
          blockedVec[i] = 1'b1;
      end
      eligMask[i] = entValid[i] && (entCnt[i] == '0) && !blockedVec[i];
    end
  end

  // R9
  alloc_free_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> !entValid[allocIdx]);

  // R8
  free_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retire |-> entValid[freeIdx]);

  for (genvar g = 0; g < DEPTH; g++) begin : gCntChk
    // R2
    cnt_down_chk: assert property (@(posedge clk) disable iff (!rstN)
      (entValid[g] && (entCnt[g] != '0) && !(strobe.take && (allocIdx == IDX_W'(g))))
      |=> (entCnt[g] == $past(entCnt[g]) - 1'b1));
  end

endmodule

// File: rtl/schedCtrl.sv
`timescale 1ns/1ps
module schedCtrl
  import sched_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  output logic             cplValid,
  input  logic             cplReady,
  input  logic [DEPTH-1:0] validMask,
  input  logic [DEPTH-1:0] eligMask,
  output tblStrobe_t       strobe,
  output logic [IDX_W-1:0] allocIdx,
  output logic [IDX_W-1:0] freeIdx,
  output logic [IDX_W-1:0] selIdx
);

  logic             anyFree;
  logic             anyElig;
  logic [IDX_W-1:0] freeSlot;
  logic [IDX_W-1:0] pickIdx;
  logic             lockValid;
  logic [IDX_W-1:0] lockIdx;

  // lowest free slot and lowest eligible slot
  always_comb begin
    anyFree  = 1'b0;
    freeSlot = '0;
    anyElig  = 1'b0;
    pickIdx  = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (!validMask[k]) begin
        anyFree  = 1'b1;
        freeSlot = IDX_W'(k);
      end
      if (eligMask[k]) begin
        anyElig = 1'b1;
        pickIdx = IDX_W'(k);
      end
    end
  end

  assign reqReady = anyFree;
  assign cplValid = lockValid | anyElig;
  assign selIdx   = lockValid ? lockIdx : pickIdx;
  assign allocIdx = freeSlot;
  assign freeIdx  = selIdx;

  always_comb begin
    strobe.take   = reqValid & reqReady;
    strobe.retire = cplValid & cplReady;
  end

  // an offer that was not taken stays pinned to its slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockValid <= 1'b0;
      lockIdx   <= '0;
    end else begin
      lockValid <= cplValid & ~cplReady;
      lockIdx   <= selIdx;
    end
  end

  // R8
  cpl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && !cplReady) |=> (cplValid && (selIdx == $past(selIdx))));

  // R4
  sel_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |-> validMask[selIdx]);

endmodule

// File: rtl/orderedCplSched.sv
`timescale 1ns/1ps
module orderedCplSched
  import sched_pkg::*;
#(
  parameter int ID_W  = 2,
  parameter int DEPTH = 4,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strictMode,
  input  logic             rdReqValid,
  output logic             rdReqReady,
  input  logic [ID_W-1:0]  rdReqId,
  input  logic [LAT_W-1:0] rdReqLat,
  output logic             rdCplValid,
  input  logic             rdCplReady,
  output logic [ID_W-1:0]  rdCplId,
  input  logic             wrReqValid,
  output logic             wrReqReady,
  input  logic [ID_W-1:0]  wrReqId,
  input  logic [LAT_W-1:0] wrReqLat,
  output logic             wrCplValid,
  input  logic             wrCplReady,
  output logic [ID_W-1:0]  wrCplId
);

  localparam int NUM_CH = 2;  // index 0 reads, index 1 writes
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             reqValidA [NUM_CH];
  logic             reqReadyA [NUM_CH];
  logic [ID_W-1:0]  reqIdA    [NUM_CH];
  logic [LAT_W-1:0] reqLatA   [NUM_CH];
  logic             cplValidA [NUM_CH];
  logic             cplReadyA [NUM_CH];
  logic [ID_W-1:0]  cplIdA    [NUM_CH];

  assign reqValidA[0] = rdReqValid;
  assign reqIdA[0]    = rdReqId;
  assign reqLatA[0]   = rdReqLat;
  assign cplReadyA[0] = rdCplReady;
  assign reqValidA[1] = wrReqValid;
  assign reqIdA[1]    = wrReqId;
  assign reqLatA[1]   = wrReqLat;
  assign cplReadyA[1] = wrCplReady;

  assign rdReqReady = reqReadyA[0];
  assign rdCplValid = cplValidA[0];
  assign rdCplId    = cplIdA[0];
  assign wrReqReady = reqReadyA[1];
  assign wrCplValid = cplValidA[1];
  assign wrCplId    = cplIdA[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : gDom
    tblStrobe_t       strobe;
    logic [IDX_W-1:0] allocIdx;
    logic [IDX_W-1:0] freeIdx;
    logic [IDX_W-1:0] selIdx;
    logic [DEPTH-1:0] validMask;
    logic [DEPTH-1:0] eligMask;

    schedCtrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uCtrl (
      .clk(clk), .rstN(rstN),
      .reqValid(reqValidA[c]), .reqReady(reqReadyA[c]),
      .cplValid(cplValidA[c]), .cplReady(cplReadyA[c]),
      .validMask(validMask), .eligMask(eligMask),
      .strobe(strobe), .allocIdx(allocIdx), .freeIdx(freeIdx), .selIdx(selIdx)
    );

    schedTable #(.DEPTH(DEPTH), .ID_W(ID_W), .LAT_W(LAT_W), .IDX_W(IDX_W)) uTable (
      .clk(clk), .rstN(rstN), .strictMode(strictMode),
      .strobe(strobe), .allocIdx(allocIdx),
      .allocId(reqIdA[c]), .allocLat(reqLatA[c]),
      .freeIdx(freeIdx), .selIdx(selIdx),
      .validMask(validMask), .eligMask(eligMask), .selId(cplIdA[c])
    );

    // R8
    cpl_id_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cplValidA[c] && !cplReadyA[c]) |=> (cplValidA[c] && $stable(cplIdA[c])));
  end

endmodule

// File: tb/tb_orderedCplSched.sv
`timescale 1ns/1ps
module tb_orderedCplSched;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strictMode = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       rqV   [2] = '{1'b0, 1'b0};
  logic [1:0] rqId  [2] = '{2'd0, 2'd0};
  logic [3:0] rqLat [2] = '{4'd0, 4'd0};
  logic       cpR   [2] = '{1'b0, 1'b0};
  logic       rqRdy [2];
  logic       cpV   [2];
  logic [1:0] cpId  [2];

  orderedCplSched dut (
    .clk(clk), .rstN(rstN), .strictMode(strictMode),
    .rdReqValid(rqV[0]), .rdReqReady(rqRdy[0]), .rdReqId(rqId[0]), .rdReqLat(rqLat[0]),
    .rdCplValid(cpV[0]), .rdCplReady(cpR[0]), .rdCplId(cpId[0]),
    .wrReqValid(rqV[1]), .wrReqReady(rqRdy[1]), .wrReqId(rqId[1]), .wrReqLat(rqLat[1]),
    .wrCplValid(cpV[1]), .wrCplReady(cpR[1]), .wrCplId(cpId[1])
  );

  int errors = 0;
  int checks = 0;
  bit running = 0;
  string phaseTag = "R1";
  int readyMode [2] = '{0, 0};  // 0 low, 1 high, 2 random

  int rdQ[$];
  int wrQ[$];

  // behavioural reference: per domain, slot-indexed entries with arrival numbers
  bit mValid [2][4];
  int mId    [2][4];
  int mRem   [2][4];
  int mSeq   [2][4];
  int seqNo  = 0;
  bit mLock  [2];
  int mLockSlot [2];
  bit accLast [2];
  bit eReady [2];
  bit eValid [2];
  int eSlot  [2];

  function automatic void check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endfunction

  function automatic bit mayGo(int ch, int s);
    if (!mValid[ch][s] || mRem[ch][s] != 0) return 0;
    for (int t = 0; t < 4; t++)
      if (t != s && mValid[ch][t] && mSeq[ch][t] < mSeq[ch][s] &&
          (strictMode || mId[ch][t] == mId[ch][s]))
        return 0;
    return 1;
  endfunction

  function automatic void computeExp(int ch);
    eReady[ch] = 0;
    for (int s = 0; s < 4; s++) if (!mValid[ch][s]) eReady[ch] = 1;
    eValid[ch] = 0;
    eSlot[ch] = 0;
    if (mLock[ch]) begin
      eValid[ch] = 1;
      eSlot[ch] = mLockSlot[ch];
    end else begin
      for (int s = 3; s >= 0; s--)
        if (mayGo(ch, s)) begin
          eValid[ch] = 1;
          eSlot[ch] = s;
        end
    end
  endfunction

  function automatic void modelStep(int ch);
    bit acc;
    bit done;
    int slot;
    acc = rqV[ch] && eReady[ch];
    done = eValid[ch] && cpR[ch];
    slot = -1;
    for (int s = 3; s >= 0; s--) if (!mValid[ch][s]) slot = s;
    for (int s = 0; s < 4; s++)
      if (mValid[ch][s] && mRem[ch][s] > 0) mRem[ch][s]--;
    if (done) mValid[ch][eSlot[ch]] = 0;
    if (acc && slot >= 0) begin
      mValid[ch][slot] = 1;
      mId[ch][slot] = int'(rqId[ch]);
      mRem[ch][slot] = int'(rqLat[ch]);
      mSeq[ch][slot] = seqNo;
      seqNo++;
    end
    mLock[ch] = eValid[ch] && !cpR[ch];
    mLockSlot[ch] = eSlot[ch];
    accLast[ch] = acc;
  endfunction

  function automatic int outstanding(int ch);
    int n = 0;
    for (int s = 0; s < 4; s++) if (mValid[ch][s]) n++;
    return n;
  endfunction

  // stepper: drive at negedge, compare 1 ns later, advance model at posedge
  initial begin
    forever begin
      @(negedge clk);
      if (running) begin
        for (int ch = 0; ch < 2; ch++) begin
          if (!rqV[ch] || accLast[ch]) begin
            int v;
            bit have;
            have = (ch == 0) ? (rdQ.size() > 0) : (wrQ.size() > 0);
            if (have) begin
              v = (ch == 0) ? rdQ.pop_front() : wrQ.pop_front();
              rqV[ch] = 1'b1;
              rqId[ch] = 2'(v / 16);
              rqLat[ch] = 4'(v % 16);
            end else begin
              rqV[ch] = 1'b0;
            end
          end
          cpR[ch] = (readyMode[ch] == 1) ? 1'b1 :
                    (readyMode[ch] == 2) ? 1'($urandom % 2) : 1'b0;
        end
        #1;
        for (int ch = 0; ch < 2; ch++) begin
          computeExp(ch);
          // R9 ready low exactly when full
          check(rqRdy[ch] == eReady[ch], phaseTag, $sformatf("R9 ch%0d reqReady", ch),
                int'(rqRdy[ch]), int'(eReady[ch]));
          // R2 / R3 / R6 / R8 completion offered in the expected cycle
          check(cpV[ch] == eValid[ch], phaseTag, $sformatf("R2 ch%0d cplValid", ch),
                int'(cpV[ch]), int'(eValid[ch]));
          // R4 / R7 the expected request is the one offered
          if (eValid[ch])
            check(int'(cpId[ch]) == mId[ch][eSlot[ch]], phaseTag,
                  $sformatf("R4 ch%0d cplId", ch), int'(cpId[ch]), mId[ch][eSlot[ch]]);
        end
        @(posedge clk);
        for (int ch = 0; ch < 2; ch++) modelStep(ch);
      end
    end
  end

  task automatic waitIdle();
    int n = 0;
    while ((rdQ.size() + wrQ.size() + outstanding(0) + outstanding(1) != 0 ||
            rqV[0] || rqV[1]) && n < 2000) begin
      @(posedge clk);
      n++;
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(13));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    for (int ch = 0; ch < 2; ch++) begin
      check(rqRdy[ch] == 1'b1, "R1", $sformatf("ch%0d reqReady after reset", ch), int'(rqRdy[ch]), 1);
      check(cpV[ch] == 1'b0, "R1", $sformatf("ch%0d cplValid after reset", ch), int'(cpV[ch]), 0);
    end
    @(posedge clk);
    running = 1;

    // R2 single read, latency 5
    phaseTag = "R2";
    readyMode = '{1, 1};
    rdQ.push_back(1 * 16 + 5);
    waitIdle();

    // R3 id1 long, id2 short: id2 overtakes
    phaseTag = "R3";
    rdQ.push_back(1 * 16 + 9);
    rdQ.push_back(2 * 16 + 0);
    waitIdle();

    // R4 same id: short latency waits behind long one
    phaseTag = "R4";
    rdQ.push_back(3 * 16 + 10);
    rdQ.push_back(3 * 16 + 0);
    rdQ.push_back(3 * 16 + 2);
    waitIdle();

    // R5 write id2 long, read id2 short: read does not wait
    phaseTag = "R5";
    wrQ.push_back(2 * 16 + 12);
    rdQ.push_back(2 * 16 + 0);
    wrQ.push_back(2 * 16 + 0);
    waitIdle();

    // R6 strict mode: arrival order across ids
    phaseTag = "R6";
    @(negedge clk);
    strictMode = 1'b1;
    rdQ.push_back(1 * 16 + 8);
    rdQ.push_back(2 * 16 + 0);
    wrQ.push_back(0 * 16 + 6);
    wrQ.push_back(3 * 16 + 1);
    waitIdle();
    @(negedge clk);
    strictMode = 1'b0;

    // R7 lower slot holds the younger request, both ready together
    phaseTag = "R7";
    rdQ.push_back(0 * 16 + 0);
    rdQ.push_back(1 * 16 + 12);
    repeat (6) @(posedge clk);
    readyMode[0] = 0;
    rdQ.push_back(2 * 16 + 3);
    repeat (20) @(posedge clk);
    readyMode[0] = 1;
    waitIdle();

    // R8 completion held under random backpressure
    phaseTag = "R8";
    readyMode = '{2, 2};
    for (int k = 0; k < 4; k++) begin
      rdQ.push_back(k * 16 + 1);
      wrQ.push_back((3 - k) * 16 + 2);
    end
    waitIdle();

    // R9 fill all four slots, fifth request stalls
    phaseTag = "R9";
    readyMode = '{0, 0};
    for (int k = 0; k < 5; k++) begin
      rdQ.push_back((k % 4) * 16 + 3);
      wrQ.push_back(((k + 1) % 4) * 16 + 4);
    end
    repeat (25) @(posedge clk);
    readyMode = '{1, 1};
    waitIdle();

    // mixed traffic with mode changes
    phaseTag = "R4";
    readyMode = '{2, 2};
    for (int it = 0; it < 40; it++) begin
      @(negedge clk);
      strictMode = 1'($urandom % 2);
      phaseTag = strictMode ? "R6" : "R4";
      for (int k = 0; k < 12; k++) begin
        rdQ.push_back(int'($urandom % 4) * 16 + int'($urandom % 16));
        wrQ.push_back(int'($urandom % 4) * 16 + int'($urandom % 16));
      end
      repeat (90) @(posedge clk);
    end
    waitIdle();
    finishRun();
  end

endmodule